// File: doc/BRIEF.md
# Fixed-Point Status Flag Generator

This unit keeps the fixed-point exception flags and the first condition field of an integer pipeline. After an integer operation it is given the 64-bit result and the two addends that produced it. It derives carry and signed overflow twice, once at the full 64-bit boundary and once at the 32-bit boundary, and stores them in a small flag register. A multiply/divide unit can also force or clear overflow directly. A separate record enable writes a 4-bit condition field. That field holds the signed comparison of the result against zero and a copy of the sticky summary-overflow flag.

Each flag group has its own update enable, so one operation can touch carry only, overflow only, the condition field only, or any mix of them in the same cycle. All outputs are registered. They change on the rising clock edge that samples the enables. The arithmetic result itself is computed elsewhere.

Top module: `fxs_status_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `ca`, `ca32`, `ov`, `ov32`, `so` and `cr0` to zero.
- R2: With `upd_ca` high, `ca` takes the carry out of bit 63 of `opa + opb + cin`, where `cin = result[0] ^ opa[0] ^ opb[0]`. Subtraction is presented as `opa + ~b + 1`.
- R3: With `upd_ca` high, `ca32` takes the carry out of bit 31 of the same addition in the same cycle.
- R4: With `upd_ov` high and `upd_mdov` low, `ov` is set when `opa[63]` equals `opb[63]` and `result[63]` differs from them, and cleared otherwise. Whenever `ov` is set, `so` is set as well.
- R5: Under the same update, `ov32` follows the same rule at bit 31, independently of `ov`. A 32-bit-only overflow does not set `so`.
- R6: With `upd_mdov` high, `ov` and `ov32` both take `md_ov`, and `so` is set when `md_ov` is 1. This path has priority over `upd_ov`.
- R7: `so` is sticky. Only reset clears it. Clearing `ov` leaves it unchanged.
- R8: With `upd_cr` high, `cr0` is {lt, gt, eq, so}. lt is in bit 3, gt in bit 2 and eq in bit 1, and they come from `result` read as a signed 64-bit value compared with zero. Bit 0 is the `so` value after any overflow update made in the same cycle.
- R9: A flag group whose enable is low keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| result | input | 64 | Result of the integer operation |
| opa | input | 64 | First addend |
| opb | input | 64 | Second addend (already inverted for subtraction) |
| upd_ca | input | 1 | Update `ca` and `ca32` |
| upd_ov | input | 1 | Update overflow from the arithmetic |
| upd_mdov | input | 1 | Update overflow from the multiply/divide request |
| md_ov | input | 1 | Multiply/divide overflow request value |
| upd_cr | input | 1 | Record the condition field |
| ca | output | 1 | Carry at 64 bits |
| ca32 | output | 1 | Carry at 32 bits |
| ov | output | 1 | Signed overflow at 64 bits |
| ov32 | output | 1 | Signed overflow at 32 bits |
| so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
Two updates can land in the same cycle. In one, an overflow update sets the summary bit. In the other, the condition-field record copies that summary bit. The bench provokes this by raising `upd_ov` and `upd_cr` together on an operation that overflows at 64 bits, starting from a clean `so`. It then requires `cr0[0]` to be 1 on the very next edge, not one operation later. A second collision raises the forced multiply/divide clear and an overflowing arithmetic update in the same cycle, and the bench expects the forced value to win.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
    localparam int unsigned FXS_W = 64;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_field_t;

    typedef struct packed {
        logic so;
        logic ov;
        logic ov32;
        logic ca;
        logic ca32;
    } flags_t;

    typedef enum logic [1:0] {
        OVS_HOLD   = 2'd0,
        OVS_ARITH  = 2'd1,
        OVS_FORCED = 2'd2
    } ov_src_t;
endpackage

// File: rtl/fxs_bound_flags.sv
module fxs_bound_flags #(
    parameter int unsigned W = 64,
    parameter int unsigned N = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    output logic         carry,
    output logic         ovf
);
    localparam int unsigned MSB = N - 1;

    logic cin_msb;

    always_comb begin
        // carry into the top bit of the window is recovered from the sum bit
        cin_msb = a[MSB] ^ b[MSB] ^ r[MSB];
        carry   = (a[MSB] & b[MSB]) | (cin_msb & (a[MSB] ^ b[MSB]));
        ovf     = (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]);
    end
endmodule

// File: rtl/fxs_cr_calc.sv
module fxs_cr_calc
    import fxs_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] r,
    input  logic         so_in,
    output cr_field_t    cr
);
    always_comb begin
        cr.lt = r[W-1];
        cr.eq = (r == '0);
        cr.gt = !r[W-1] && (r != '0);
        cr.so = so_in;
    end
endmodule

// File: rtl/fxs_status_unit.sv
module fxs_status_unit
    import fxs_pkg::*;
#(
    parameter int unsigned W = FXS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] result,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         upd_ca,
    input  logic         upd_ov,
    input  logic         upd_mdov,
    input  logic         md_ov,
    input  logic         upd_cr,
    output logic         ca,
    output logic         ca32,
    output logic         ov,
    output logic         ov32,
    output logic         so,
    output logic [3:0]   cr0
);
    localparam int unsigned HALF   = W / 2;
    localparam int unsigned NBOUND = 2;

    logic [NBOUND-1:0] carry_v;
    logic [NBOUND-1:0] ovf_v;

    // index 0: full width, index 1: lower half
    for (genvar g = 0; g < NBOUND; g++) begin : g_bound
        localparam int unsigned NB = (g == 0) ? W : HALF;
        fxs_bound_flags #(.W(W), .N(NB)) u_bf (
            .a     (opa),
            .b     (opb),
            .r     (result),
            .carry (carry_v[g]),
            .ovf   (ovf_v[g])
        );
    end

    flags_t    flg_q, flg_d;
    cr_field_t cr_q, cr_d;
    ov_src_t   ov_src;

    always_comb begin
        if (upd_mdov)    ov_src = OVS_FORCED;
        else if (upd_ov) ov_src = OVS_ARITH;
        else             ov_src = OVS_HOLD;
    end

    always_comb begin
        flg_d = flg_q;
        if (upd_ca) begin
            flg_d.ca   = carry_v[0];
            flg_d.ca32 = carry_v[1];
        end
        unique case (ov_src)
            OVS_FORCED: begin
                flg_d.ov   = md_ov;
                flg_d.ov32 = md_ov;
                flg_d.so   = flg_q.so | md_ov;
            end
            OVS_ARITH: begin
                flg_d.ov   = ovf_v[0];
                flg_d.ov32 = ovf_v[1];
                flg_d.so   = flg_q.so | ovf_v[0];
            end
            default: ;
        endcase
    end

    cr_field_t cr_new;

    fxs_cr_calc #(.W(W)) u_cr (
        .r     (result),
        .so_in (flg_d.so),
        .cr    (cr_new)
    );

    always_comb cr_d = upd_cr ? cr_new : cr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
            cr_q  <= '0;
        end else begin
            flg_q <= flg_d;
            cr_q  <= cr_d;
        end
    end

    always_comb begin
        ca   = flg_q.ca;
        ca32 = flg_q.ca32;
        ov   = flg_q.ov;
        ov32 = flg_q.ov32;
        so   = flg_q.so;
        cr0  = cr_q;
    end
endmodule

// File: rtl/fxs_status_chk.sv
module fxs_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       upd_ca,
    input logic       upd_mdov,
    input logic       md_ov,
    input logic       upd_cr,
    input logic       ca,
    input logic       ca32,
    input logic       ov,
    input logic       ov32,
    input logic       so,
    input logic [3:0] cr0
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> ({ca, ca32, ov, ov32, so, cr0} == 9'd0));

    assert_ov_implies_so_R4: assert property (@(posedge clk) disable iff (rst)
        ov |-> so);

    assert_forced_ov_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_mdov && md_ov) |=> (ov && ov32 && so));

    assert_so_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !$fell(so));

    assert_cr_so_copy_R8: assert property (@(posedge clk) disable iff (rst)
        upd_cr |=> (cr0[0] == so));

    assert_cr_one_relation_R8: assert property (@(posedge clk) disable iff (rst)
        upd_cr |=> ($countones(cr0[3:1]) == 1));

    assert_carry_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !upd_ca |=> $stable({ca, ca32}));
endmodule

bind fxs_status_unit fxs_status_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .upd_ca   (upd_ca),
    .upd_mdov (upd_mdov),
    .md_ov    (md_ov),
    .upd_cr   (upd_cr),
    .ca       (ca),
    .ca32     (ca32),
    .ov       (ov),
    .ov32     (ov32),
    .so       (so),
    .cr0      (cr0)
);

// File: tb/fxs_status_unit_bench.sv
module fxs_status_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] result = '0, opa = '0, opb = '0;
    logic        upd_ca = 0, upd_ov = 0, upd_mdov = 0, md_ov = 0, upd_cr = 0;
    logic        ca, ca32, ov, ov32, so;
    logic [3:0]  cr0;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the flag state
    logic       m_ca = 0, m_ca32 = 0, m_ov = 0, m_ov32 = 0, m_so = 0;
    logic [3:0] m_cr = '0;

    always #4 clk = ~clk;

    fxs_status_unit u_fxs_status_unit (
        .clk(clk), .rst(rst), .result(result), .opa(opa), .opb(opb),
        .upd_ca(upd_ca), .upd_ov(upd_ov), .upd_mdov(upd_mdov), .md_ov(md_ov),
        .upd_cr(upd_cr), .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32),
        .so(so), .cr0(cr0)
    );

    task automatic check(input string req, input string what);
        logic [8:0] act, exp;
        act = {ca, ca32, ov, ov32, so, cr0};
        exp = {m_ca, m_ca32, m_ov, m_ov32, m_so, m_cr};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s): actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        {m_ca, m_ca32, m_ov, m_ov32, m_so} = '0;
        m_cr = '0;
        check(req, "state after reset");
    endtask

    // one operation: a + (sub ? ~b : b) + sub, with the chosen enables
    task automatic op(input logic [63:0] a, input logic [63:0] b, input logic sub,
                      input logic e_ca, input logic e_ov, input logic e_md,
                      input logic v_md, input logic e_cr,
                      input string req, input string what);
        logic [63:0]        bb;
        logic [64:0]        s64;
        logic [32:0]        s32;
        logic signed [64:0] w64;
        logic signed [32:0] w32;
        logic               o64, o32, sgn_neg, is_zero;
        bb  = sub ? ~b : b;
        s64 = {1'b0, a} + {1'b0, bb} + {64'd0, sub};
        s32 = {1'b0, a[31:0]} + {1'b0, bb[31:0]} + {32'd0, sub};
        w64 = $signed({a[63], a}) + $signed({bb[63], bb}) + $signed({64'd0, sub});
        w32 = $signed({a[31], a[31:0]}) + $signed({bb[31], bb[31:0]}) + $signed({32'd0, sub});
        o64 = (w64[64] != w64[63]);
        o32 = (w32[32] != w32[31]);
        @(negedge clk);
        opa = a; opb = bb; result = s64[63:0];
        upd_ca = e_ca; upd_ov = e_ov; upd_mdov = e_md; md_ov = v_md; upd_cr = e_cr;
        if (e_ca) begin m_ca = s64[64]; m_ca32 = s32[32]; end
        if (e_md) begin
            m_ov = v_md; m_ov32 = v_md; if (v_md) m_so = 1'b1;
        end else if (e_ov) begin
            m_ov = o64; m_ov32 = o32; if (o64) m_so = 1'b1;
        end
        sgn_neg = s64[63];
        is_zero = (s64[63:0] == 64'd0);
        if (e_cr) m_cr = {sgn_neg, !sgn_neg && !is_zero, is_zero, m_so};
        @(negedge clk);
        {upd_ca, upd_ov, upd_mdov, md_ov, upd_cr} = '0;
        check(req, what);
    endtask

    task automatic t_carry;
        op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 0, 0, 0, 0, "R2", "carry out of both boundaries");
        op(64'h0000_0000_FFFF_FFFF, 64'd1, 0, 1, 0, 0, 0, 0, "R3", "carry at 32 only");
        op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 1, 0, 0, 0, 0, "R2", "carry at 64 only");
        op(64'd9, 64'd9, 1, 1, 0, 0, 0, 0, "R2", "subtract equal gives carry");
    endtask

    task automatic t_overflow;
        op(64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0, 1, 0, 0, 0, "R5", "32-bit overflow alone leaves so clear");
        op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 1, 0, 0, 0, "R4", "64-bit overflow sets so");
        op(64'd3, 64'd4, 0, 0, 1, 0, 0, 0, "R7", "ov cleared, so kept");
        op(64'h8000_0000_0000_0000, 64'd1, 1, 0, 1, 0, 0, 0, "R4", "subtract overflow");
    endtask

    task automatic t_forced;
        op(64'd1, 64'd1, 0, 0, 0, 1, 1, 0, "R6", "forced overflow sets all");
        op(64'd1, 64'd1, 0, 0, 0, 1, 0, 0, "R6", "forced clear keeps so");
        op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 1, 1, 0, 0, "R6", "forced clear beats arith overflow");
    endtask

    task automatic t_record;
        op(64'd5, 64'd6, 0, 0, 0, 0, 0, 1, "R8", "positive result");
        op(64'd5, 64'd6, 1, 0, 0, 0, 0, 1, "R8", "negative result");
        op(64'd7, 64'd7, 1, 1, 0, 0, 0, 1, "R8", "zero result");
        op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 1, 0, 0, 1, "R8", "same-cycle so into cr0");
    endtask

    task automatic t_hold;
        op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 1, 0, "R9", "no enable, flags kept");
        op(64'd0, 64'd0, 0, 0, 0, 0, 0, 0, "R9", "zero result without record");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        do_reset("R1");
        t_carry();
        t_overflow();
        t_hold();
        do_reset("R1");
        t_forced();
        do_reset("R1");
        t_record();
        t_hold();
        do_reset("R1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule